// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer whose write port and read port run on independent clocks, so words can be stored and fetched in the same moment. Storage is an inferred dual-port RAM of `2**ADDR_W` words. Pointers pass between the two clock domains in Gray code through two-flop synchronizers. The write domain computes full, half-full and almost-full from its own pointer and the synchronized read pointer. The read domain computes empty and almost-empty from its own pointer and the synchronized write pointer. All flags are active high.

Master reset samples several configuration pins: read timing, flag timing, how offsets are programmed, and a three-bit preset index. It loads both almost-flag offsets with the preset value. The offsets can later be rewritten through the data bus or through a serial shift input. Partial reset empties the buffer but keeps offsets and modes. Retransmit rewinds the read side to the first stored word. A read needs both read enable and read chip select.

The read side is a three-state machine. `RS_STD` is standard timing: a read loads the output register one cycle later. In first-word-fall-through timing the machine starts in `RS_FW_VOID` (output register holds nothing) and moves to `RS_FW_HELD` as soon as a word is present, with no read request (*fetch*). It falls back from `RS_FW_HELD` to `RS_FW_VOID` when a read finds no word behind it (*drain*). A retransmit with data stored moves to `RS_FW_HELD` (*rewind*). The offset loader on the write side is a two-state machine. `LD_EMPTY_OFF` takes the next parallel load into the almost-empty offset and moves to `LD_FULL_OFF`. `LD_FULL_OFF` takes the next load into the almost-full offset and moves back. Either reset returns it to `LD_EMPTY_OFF`.

Top module: `pfifo_top`

## Requirements
- R1: While `mrst` is high, the pins `{ld, preset_sel}` form an index i in 0..7, and both offsets become i+1. After release the buffer is empty, with `empty_or`=1, `full_ir`=0, `half_full`=0, `almost_empty`=1, `almost_full`=0 and `dout`=0.
- R2: In standard timing with n settled words and depth D: `empty_or` = (n==0), `full_ir` = (n==D), `half_full` = (n>D/2), `almost_empty` = (n <= empty offset), `almost_full` = (n >= D - full offset).
- R3: In standard timing, a read loads the oldest word into `dout` on the read clock edge that samples the request, and words leave in the order they were written.
- R4: A write while full and a read while empty are ignored. Neither pointer moves, and `dout` keeps its value.
- R5: First-word-fall-through timing (`fwft_sel`=1 at master reset): the first word reaches `dout` with no read, and `empty_or` means output-ready. The capacity is D+1, `full_ir` means input-ready = (n < D+1), `half_full` = (n >= D/2+2), `almost_empty` = (n <= empty offset), `almost_full` = (n >= D+1 - full offset).
- R6: With `serial_cfg_sel`=0 at master reset, a cycle with `ld`=1 and `wen`=1 stores nothing. It loads `din[ADDR_W-1:0]` into the almost-empty offset, and the next such cycle loads the almost-full offset, alternating.
- R7: With `serial_cfg_sel`=1, each write-clock cycle with `ser_en`=1 shifts `ser_din` into a 2*ADDR_W-bit register, LSB first. After 2*ADDR_W bits, the first ADDR_W bits are the almost-empty offset and the next ADDR_W bits are the almost-full offset. Parallel loads are ignored in this mode.
- R8: Partial reset (`prst`) discards all stored words and keeps the programmed offsets and modes.
- R9: Retransmit (`rt`) rewinds reading to the first word written since reset, with no added cycles. In first-word-fall-through timing, that word is on `dout` at the edge that samples `rt`.
- R10: With `async_flag_sel`=0, the almost flags use the synchronized pointer of the other port and clear two clock edges late. With `async_flag_sel`=1, they follow both raw pointers, so `almost_full` clears right after the read edge and `almost_empty` clears right after the write edge.
- R11: A read request with `rcs`=0 is ignored, even with `ren`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, synchronous in each domain, active high |
| prst | input | 1 | Partial reset, synchronous in each domain, active high |
| fwft_sel | input | 1 | Read timing, sampled at master reset: 1 = first-word-fall-through |
| async_flag_sel | input | 1 | Almost-flag timing, sampled at master reset: 1 = asynchronous |
| serial_cfg_sel | input | 1 | Offset programming, sampled at master reset: 1 = serial |
| preset_sel | input | 2 | Low bits of the preset index |
| wen | input | 1 | Write enable |
| ld | input | 1 | Offset load strobe; high bit of the preset index during master reset |
| din | input | DATA_W | Write data, and offset value for parallel loads |
| ser_en | input | 1 | Serial shift enable (write clock) |
| ser_din | input | 1 | Serial offset bit |
| ren | input | 1 | Read enable |
| rcs | input | 1 | Read chip select |
| rt | input | 1 | Retransmit |
| dout | output | DATA_W | Output register |
| empty_or | output | 1 | Empty (standard) or output-ready (first-word-fall-through) |
| full_ir | output | 1 | Full (standard) or input-ready (first-word-fall-through) |
| half_full | output | 1 | More than half full |
| almost_empty | output | 1 | Programmable almost-empty |
| almost_full | output | 1 | Programmable almost-full |

## Verification
The properties assume that both resets are held for several edges of each clock. They also assume that retransmit is used only while no more than D words have been written since the last reset, and that the offsets are reprogrammed only when the pointers are still. The stimulus drives both ports from one clock and reprograms only right after a reset. It lets the pointer synchronizers settle before every flag sample and issues retransmit only after at most five writes. Boundary sweeps fill the buffer one word at a time under every preset and every programmed offset pair.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

    typedef enum logic [1:0] {
        RS_STD,
        RS_FW_VOID,
        RS_FW_HELD
    } rd_state_t;

    typedef enum logic {
        LD_EMPTY_OFF,
        LD_FULL_OFF
    } ld_state_t;

    function automatic int preset_offset(input logic [2:0] idx);
        return int'(idx) + 1;
    endfunction

endpackage

// File: rtl/pfifo_sync.sv
module pfifo_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage1, stage2;

    always_ff @(posedge clk) begin
        if (clr) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_g2b
        assign bin_out[i] = ^(stage2 >> i);
    end
endmodule

// File: rtl/pfifo_wr_side.sv
module pfifo_wr_side
    import pfifo_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int PW    = ADDR_W + 1,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              fwft_pin,
    input  logic              async_pin,
    input  logic              serial_pin,
    input  logic [1:0]        preset_sel,
    input  logic              wen,
    input  logic              ld,
    input  logic [ADDR_W-1:0] cfg_word,
    input  logic              ser_en,
    input  logic              ser_din,
    input  logic [PW-1:0]     rptr_sync,
    input  logic [PW-1:0]     rptr_raw,
    output logic [PW-1:0]     wptr,
    output logic [PW-1:0]     wptr_gray,
    output logic              push,
    output logic              full,
    output logic              full_ir,
    output logic              half_full,
    output logic              almost_full,
    output logic [ADDR_W-1:0] pae_off
);
    logic              rst_any;
    logic              fwft_q, async_q, serial_q;
    logic [ADDR_W-1:0] paf_off;
    ld_state_t         ld_st, ld_st_nx;
    logic              par_ld;
    logic [PW-1:0]     wcount, flag_count, wnext;

    assign rst_any    = mrst | prst;
    assign wcount     = wptr - rptr_sync;
    assign full       = (wcount == PW'(DEPTH));
    assign push       = wen & ~ld & ~full & ~rst_any;
    assign par_ld     = wen & ld & ~serial_q & ~rst_any;
    assign wnext      = wptr + PW'(1);

    // mode and offset registers
    always_ff @(posedge clk) begin
        if (mrst) begin
            fwft_q   <= fwft_pin;
            async_q  <= async_pin;
            serial_q <= serial_pin;
            pae_off  <= ADDR_W'(preset_offset({ld, preset_sel}));
            paf_off  <= ADDR_W'(preset_offset({ld, preset_sel}));
        end else if (!prst) begin
            if (serial_q && ser_en) begin
                {paf_off, pae_off} <= {ser_din, paf_off, pae_off[ADDR_W-1:1]};
            end else if (par_ld) begin
                if (ld_st == LD_EMPTY_OFF) pae_off <= cfg_word;
                else                       paf_off <= cfg_word;
            end
        end
    end

    // loader state register
    always_ff @(posedge clk) begin
        if (rst_any) ld_st <= LD_EMPTY_OFF;
        else         ld_st <= ld_st_nx;
    end

    // loader next state
    always_comb begin
        ld_st_nx = ld_st;
        unique case (ld_st)
            LD_EMPTY_OFF: if (par_ld) ld_st_nx = LD_FULL_OFF;
            LD_FULL_OFF:  if (par_ld) ld_st_nx = LD_EMPTY_OFF;
            default:      ld_st_nx = LD_EMPTY_OFF;
        endcase
    end

    // write pointer, binary and Gray
    always_ff @(posedge clk) begin
        if (rst_any) begin
            wptr      <= '0;
            wptr_gray <= '0;
        end else if (push) begin
            wptr      <= wnext;
            wptr_gray <= wnext ^ (wnext >> 1);
        end
    end

    // status outputs
    always_comb begin
        flag_count  = async_q ? (wptr - rptr_raw) : wcount;
        full_ir     = fwft_q ? ~full : full;
        half_full   = (wcount > PW'(DEPTH / 2));
        almost_full = (flag_count >= (PW'(DEPTH) - PW'(paf_off)));
    end
endmodule

// File: rtl/pfifo_rd_side.sv
module pfifo_rd_side
    import pfifo_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    localparam int PW    = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              fwft_pin,
    input  logic              async_pin,
    input  logic              ren,
    input  logic              rcs,
    input  logic              rt,
    input  logic [PW-1:0]     wptr_sync,
    input  logic [PW-1:0]     wptr_raw,
    input  logic [ADDR_W-1:0] pae_off,
    input  logic [DATA_W-1:0] ram_q,
    output logic [ADDR_W-1:0] raddr,
    output logic [PW-1:0]     rptr,
    output logic [PW-1:0]     rptr_gray,
    output logic [DATA_W-1:0] dout,
    output logic              ram_empty,
    output logic              fwft_mode,
    output logic              empty_or,
    output logic              almost_empty
);
    logic          rst_any, async_q, rd_req, stored;
    rd_state_t     rd_st, rd_st_nx;
    logic          take, rewind, load_first;
    logic [PW-1:0] rnext, rcount, flag_count;

    assign rst_any   = mrst | prst;
    assign rd_req    = ren & rcs;
    assign rcount    = wptr_sync - rptr;
    assign ram_empty = (rcount == '0);
    assign stored    = (wptr_sync != '0);

    always_ff @(posedge clk) begin
        if (mrst) begin
            fwft_mode <= fwft_pin;
            async_q   <= async_pin;
        end
    end

    // read state register
    always_ff @(posedge clk) begin
        if (mrst)      rd_st <= fwft_pin ? RS_FW_VOID : RS_STD;
        else if (prst) rd_st <= fwft_mode ? RS_FW_VOID : RS_STD;
        else           rd_st <= rd_st_nx;
    end

    // next state and actions
    always_comb begin
        rd_st_nx   = rd_st;
        take       = 1'b0;
        rewind     = 1'b0;
        load_first = 1'b0;
        unique case (rd_st)
            RS_STD: begin
                if (rt)                       rewind = 1'b1;
                else if (rd_req && !ram_empty) take  = 1'b1;
            end
            RS_FW_VOID: begin
                if (rt) begin
                    rewind = 1'b1;
                    if (stored) begin
                        load_first = 1'b1;
                        rd_st_nx   = RS_FW_HELD;
                    end
                end else if (!ram_empty) begin
                    take     = 1'b1;
                    rd_st_nx = RS_FW_HELD;
                end
            end
            RS_FW_HELD: begin
                if (rt) begin
                    rewind = 1'b1;
                    if (stored) load_first = 1'b1;
                    else        rd_st_nx   = RS_FW_VOID;
                end else if (rd_req) begin
                    if (!ram_empty) take     = 1'b1;
                    else            rd_st_nx = RS_FW_VOID;
                end
            end
            default: rd_st_nx = RS_STD;
        endcase
        if (rst_any) begin
            take       = 1'b0;
            rewind     = 1'b0;
            load_first = 1'b0;
        end
    end

    assign raddr = load_first ? '0 : rptr[ADDR_W-1:0];
    assign rnext = rewind ? (load_first ? PW'(1) : '0) : (rptr + PW'(1));

    // pointer and output register
    always_ff @(posedge clk) begin
        if (rst_any) begin
            rptr      <= '0;
            rptr_gray <= '0;
            dout      <= '0;
        end else begin
            if (rewind || take) begin
                rptr      <= rnext;
                rptr_gray <= rnext ^ (rnext >> 1);
            end
            if (take || load_first) dout <= ram_q;
        end
    end

    // status outputs
    always_comb begin
        flag_count   = (async_q ? (wptr_raw - rptr) : rcount)
                     + PW'(rd_st == RS_FW_HELD);
        empty_or     = fwft_mode ? (rd_st == RS_FW_HELD) : ram_empty;
        almost_empty = (flag_count <= PW'(pae_off));
    end
endmodule

// File: rtl/pfifo_top.sv
module pfifo_top #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              fwft_sel,
    input  logic              async_flag_sel,
    input  logic              serial_cfg_sel,
    input  logic [1:0]        preset_sel,
    input  logic              wen,
    input  logic              ld,
    input  logic [DATA_W-1:0] din,
    input  logic              ser_en,
    input  logic              ser_din,
    input  logic              ren,
    input  logic              rcs,
    input  logic              rt,
    output logic [DATA_W-1:0] dout,
    output logic              empty_or,
    output logic              full_ir,
    output logic              half_full,
    output logic              almost_empty,
    output logic              almost_full
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wptr, wptr_gray, rptr, rptr_gray, wptr_sync, rptr_sync;
    logic [ADDR_W-1:0] pae_off, raddr;
    logic [DATA_W-1:0] ram_q;
    logic              push, w_full, r_empty, r_fwft;

    always_ff @(posedge wclk) begin
        if (push) mem[wptr[ADDR_W-1:0]] <= din;
    end
    assign ram_q = mem[raddr];

    pfifo_sync #(.W(PW)) u_r2w (
        .clk(wclk), .clr(mrst | prst), .gray_in(rptr_gray), .bin_out(rptr_sync)
    );

    pfifo_sync #(.W(PW)) u_w2r (
        .clk(rclk), .clr(mrst | prst), .gray_in(wptr_gray), .bin_out(wptr_sync)
    );

    pfifo_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .clk(wclk), .mrst(mrst), .prst(prst),
        .fwft_pin(fwft_sel), .async_pin(async_flag_sel), .serial_pin(serial_cfg_sel),
        .preset_sel(preset_sel), .wen(wen), .ld(ld), .cfg_word(din[ADDR_W-1:0]),
        .ser_en(ser_en), .ser_din(ser_din),
        .rptr_sync(rptr_sync), .rptr_raw(rptr),
        .wptr(wptr), .wptr_gray(wptr_gray), .push(push), .full(w_full),
        .full_ir(full_ir), .half_full(half_full), .almost_full(almost_full),
        .pae_off(pae_off)
    );

    pfifo_rd_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(rclk), .mrst(mrst), .prst(prst),
        .fwft_pin(fwft_sel), .async_pin(async_flag_sel),
        .ren(ren), .rcs(rcs), .rt(rt),
        .wptr_sync(wptr_sync), .wptr_raw(wptr), .pae_off(pae_off), .ram_q(ram_q),
        .raddr(raddr), .rptr(rptr), .rptr_gray(rptr_gray), .dout(dout),
        .ram_empty(r_empty), .fwft_mode(r_fwft),
        .empty_or(empty_or), .almost_empty(almost_empty)
    );
endmodule

// File: rtl/pfifo_chk.sv
module pfifo_chk #(
    parameter int PW = 5
) (
    input logic          wclk,
    input logic          rclk,
    input logic          mrst,
    input logic          prst,
    input logic          wen,
    input logic          ld,
    input logic          ren,
    input logic          rcs,
    input logic          rt,
    input logic          w_full,
    input logic          r_empty,
    input logic          r_fwft,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] wptr_gray,
    input logic [PW-1:0] rptr,
    input logic [PW-1:0] rptr_gray
);
    // R4
    wr_full_hold_chk: assert property (@(posedge wclk) disable iff (mrst || prst)
        (w_full && wen && !ld) |=> $stable(wptr));

    // R4
    rd_empty_hold_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
        (!r_fwft && r_empty && ren && rcs && !rt) |=> $stable(rptr));

    // R3
    rd_advance_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
        (!r_fwft && !r_empty && ren && rcs && !rt) |=> (rptr == $past(rptr) + PW'(1)));

    // R9
    rt_rewind_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
        (!r_fwft && rt) |=> (rptr == '0));

    // R11
    rcs_block_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
        (!r_fwft && !rcs && !rt) |=> $stable(rptr));

    // R10
    wgray_step_chk: assert property (@(posedge wclk) disable iff (mrst || prst)
        $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

    // R10
    rgray_step_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
        $countones(rptr_gray ^ $past(rptr_gray)) <= 1);
endmodule

bind pfifo_top pfifo_chk #(.PW(ADDR_W + 1)) u_chk (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst),
    .wen(wen), .ld(ld), .ren(ren), .rcs(rcs), .rt(rt),
    .w_full(w_full), .r_empty(r_empty), .r_fwft(r_fwft),
    .wptr(wptr), .wptr_gray(wptr_gray), .rptr(rptr), .rptr_gray(rptr_gray)
);

// File: tb/sim_pfifo_top.sv
module sim_pfifo_top;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int D  = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          mrst = 1'b1, prst = 1'b0;
    logic          fwft_sel = 0, async_flag_sel = 0, serial_cfg_sel = 0;
    logic [1:0]    preset_sel = 2'd0;
    logic          wen = 0, ld = 0, ser_en = 0, ser_din = 0, ren = 0, rcs = 1, rt = 0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          empty_or, full_ir, half_full, almost_empty, almost_full;

    int checks = 0;
    int errors = 0;

    pfifo_top #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst),
        .fwft_sel(fwft_sel), .async_flag_sel(async_flag_sel),
        .serial_cfg_sel(serial_cfg_sel), .preset_sel(preset_sel),
        .wen(wen), .ld(ld), .din(din), .ser_en(ser_en), .ser_din(ser_din),
        .ren(ren), .rcs(rcs), .rt(rt), .dout(dout),
        .empty_or(empty_or), .full_ir(full_ir), .half_full(half_full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_flags(input int n, input bit fw, input int eo, input int fo);
        if (!fw) return {n == 0, n == D, n > D / 2, n <= eo, n >= D - fo};
        return {n > 0, n < D + 1, n >= D / 2 + 2, n <= eo, n >= D + 1 - fo};
    endfunction

    function automatic logic [4:0] flags();
        return {empty_or, full_ir, half_full, almost_empty, almost_full};
    endfunction

    task automatic mreset(input bit fw, input bit asy, input bit ser, input logic [2:0] idx);
        fwft_sel = fw; async_flag_sel = asy; serial_cfg_sel = ser;
        ld = idx[2]; preset_sel = idx[1:0]; mrst = 1'b1;
        repeat (4) @(negedge clk);
        mrst = 1'b0; ld = 1'b0;
        @(negedge clk);
    endtask

    task automatic preset_clear();
        prst = 1'b1;
        repeat (4) @(negedge clk);
        prst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [DW-1:0] d);
        wen = 1'b1; din = d;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic rd();
        ren = 1'b1; rcs = 1'b1;
        @(negedge clk);
        ren = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic sweep(input bit fw, input int eo, input int fo, input string req);
        for (int n = 0; n <= (fw ? D + 1 : D); n++) begin
            if (n > 0) begin
                wr(DW'(n));
                settle();
            end
            chk(req, 32'(flags()), 32'(exp_flags(n, fw, eo, fo)));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state with preset index 2 (offsets 3)
        mreset(0, 0, 0, 3'd2);
        chk("R1", 32'(flags()), 32'(exp_flags(0, 0, 3, 3)));
        chk("R1", 32'(dout), 32'h0);

        // R2: standard flag sweep
        sweep(0, 3, 3, "R2");

        // R4: write while full ignored, R3: order and one-cycle read
        wr(8'hAA);
        settle();
        for (int n = 1; n <= D; n++) begin
            rd();
            chk("R3", 32'(dout), 32'(n));
        end
        chk("R4", 32'(empty_or), 32'h1);
        rd();
        chk("R4", 32'(dout), 32'(D));
        wr(8'h55);
        settle();
        rd();
        chk("R4", 32'(dout), 32'h55);

        // R11: chip select blocks the read
        wr(8'h01); wr(8'h02);
        settle();
        ren = 1'b1; rcs = 1'b0;
        @(negedge clk);
        ren = 1'b0; rcs = 1'b1;
        chk("R11", 32'(dout), 32'h55);
        rd();
        chk("R11", 32'(dout), 32'h01);
        rd();
        chk("R11", 32'(dout), 32'h02);

        // R9: retransmit in standard timing
        preset_clear();
        for (int i = 0; i < 5; i++) wr(DW'(8'h0A + i));
        settle();
        for (int i = 0; i < 3; i++) rd();
        rt = 1'b1;
        @(negedge clk);
        rt = 1'b0;
        for (int i = 0; i < 5; i++) begin
            rd();
            chk("R9", 32'(dout), 32'(8'h0A + i));
        end

        // R6: parallel load of offsets 5 / 2
        preset_clear();
        ld = 1'b1; wen = 1'b1; din = 8'h05;
        @(negedge clk);
        din = 8'h02;
        @(negedge clk);
        ld = 1'b0; wen = 1'b0;
        settle();
        chk("R6", 32'(flags()), 32'(exp_flags(0, 0, 5, 2)));
        sweep(0, 5, 2, "R6");

        // R8: partial reset keeps offsets
        preset_clear();
        chk("R8", 32'(flags()), 32'(exp_flags(0, 0, 5, 2)));
        sweep(0, 5, 2, "R8");

        // R1: every preset index
        for (int idx = 0; idx < 8; idx++) begin
            mreset(0, 0, 0, 3'(idx));
            sweep(0, idx + 1, idx + 1, "R1");
        end

        // R7: serial load, empty offset 6 then full offset 1
        mreset(0, 0, 1, 3'd0);
        begin
            logic [7:0] v;
            v = {4'd1, 4'd6};
            for (int i = 0; i < 8; i++) begin
                ser_en = 1'b1; ser_din = v[i];
                @(negedge clk);
            end
            ser_en = 1'b0;
        end
        ld = 1'b1; wen = 1'b1; din = 8'h09;
        @(negedge clk);
        ld = 1'b0; wen = 1'b0;
        settle();
        sweep(0, 6, 1, "R7");

        // R5: first-word-fall-through
        mreset(1, 0, 0, 3'd2);
        chk("R5", 32'(flags()), 32'(exp_flags(0, 1, 3, 3)));
        sweep(1, 3, 3, "R5");
        chk("R5", 32'(dout), 32'h01);
        for (int i = 1; i <= D + 1; i++) begin
            chk("R5", 32'(dout), 32'(i));
            rd();
        end
        chk("R5", 32'(empty_or), 32'h0);

        // R9: zero-latency retransmit in first-word-fall-through
        preset_clear();
        wr(8'h21); wr(8'h22); wr(8'h23);
        settle();
        rd();
        chk("R9", 32'(dout), 32'h22);
        rt = 1'b1;
        @(negedge clk);
        rt = 1'b0;
        chk("R9", 32'(dout), 32'h21);

        // R10: almost-full clear timing, synchronous then asynchronous
        mreset(0, 0, 0, 3'd2);
        for (int i = 0; i < D - 3; i++) wr(DW'(i));
        settle();
        chk("R10", 32'(almost_full), 32'h1);
        rd();
        chk("R10", 32'(almost_full), 32'h1);
        mreset(0, 1, 0, 3'd2);
        for (int i = 0; i < D - 3; i++) wr(DW'(i));
        settle();
        rd();
        chk("R10", 32'(almost_full), 32'h0);

        // R10: almost-empty clear timing
        mreset(0, 0, 0, 3'd2);
        for (int i = 0; i < 3; i++) wr(DW'(i));
        settle();
        wr(8'h30);
        chk("R10", 32'(almost_empty), 32'h1);
        mreset(0, 1, 0, 3'd2);
        for (int i = 0; i < 3; i++) wr(DW'(i));
        settle();
        wr(8'h30);
        chk("R10", 32'(almost_empty), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule